// File: doc/BRIEF.md
# SD Host Block Transfer Sequencer

This block paces the data phase of an SD/MMC host controller. Software first loads a block setup word with a byte length per block and a block count. It then issues a command word whose flags say whether data follows, which way it flows and whether the count is honoured. The sequencer works out how many 32-bit words make up one block. It then opens a buffer window one block at a time. Each time a window opens, it gives a single-cycle ready event: read-ready when data flows from card to host, write-ready when it flows from host to card.

While a window is open, each data-port access in the matching direction uses up one word. When the last word of a block has been moved, the window closes. The next block's window reopens after a fixed refill latency. After the final block a single-cycle completion event is given and the sequencer returns to idle. The buffer itself is modelled only by counters. The remaining-block and remaining-word counts are brought out so the host side can observe progress.

Top module: `sd_xfer_seq`

## Requirements
- R1: A setup write latches the byte length from bits [11:0] and the block count from bits [31:16]. A block holds ceil(length/4) words, and a length of 0 is treated as one word. The word count is shown on `words_left` when a window opens.
- R2: A command starts a transfer only when bit 21 (data present) is set. Bit 4 selects the direction (1 = read from card, 0 = write to card). A command with bit 21 clear leaves `busy` low.
- R3: Unless command bits 5 (multi-block) and 1 (count enable) are both set, exactly one block is transferred and the count field is ignored.
- R4: With bits 5 and 1 both set, the number of blocks is the latched count. `blocks_left` shows the blocks not yet finished.
- R5: A window opens FILL_LAT cycles after the command is accepted, and again FILL_LAT cycles after the last word of each non-final block. On opening, `brr_evt` (read) or `bwr_evt` (write) is high for exactly one cycle. `rd_open`/`wr_open` stay high while the window is open.
- R6: Each data-port access in the open direction decrements `words_left` by one. After the last word of a non-final block, the window closes and `busy` stays high.
- R7: A data-port access while no window is open, or one in the opposite direction, changes neither `words_left` nor `blocks_left`.
- R8: The last word of the last block raises `tc_evt` for one cycle, and `busy` drops on the same edge.
- R9: A counted multi-block command with a count of 0 gives `tc_evt` on the next cycle without opening any window.
- R10: A command or setup write that arrives while busy does not alter the running transfer.
- R11: After reset the block is idle: no window open, no events, and both counts are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| blk_wr | input | 1 | Setup word write strobe |
| blk_wdata | input | 32 | Setup word: length [11:0], count [31:16] |
| cmd_wr | input | 1 | Command issue strobe |
| cmd_wdata | input | 32 | Command word flags (bits 21, 5, 4, 1) |
| dport_rd | input | 1 | Data-port read access (one word) |
| dport_wr | input | 1 | Data-port write access (one word) |
| busy | output | 1 | Transfer in progress |
| rd_open | output | 1 | Read window open |
| wr_open | output | 1 | Write window open |
| brr_evt | output | 1 | Read-ready event, one cycle per block |
| bwr_evt | output | 1 | Write-ready event, one cycle per block |
| tc_evt | output | 1 | Transfer-complete event |
| blocks_left | output | 16 | Blocks not yet finished |
| words_left | output | 11 | Words remaining in the open block |

## Verification
A block counter that is off by one shows up as a missing or extra window. It appears at the port no later than the refill gap after the block where the count went wrong, or as `tc_evt` firing a block early. A word counter that drifts, or an ignored access that leaks into it, moves `words_left` at the very next edge. It also shifts the closing edge of the window, so the following ready event comes early or late. A wrong direction latch swaps which ready event and which open level appear in the same cycle the first window opens.

// File: rtl/sdx_pkg.sv
package sdx_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_FILL = 2'd1,
      SQ_OPEN = 2'd2
   } sdx_state_e;

   localparam int CMD_DATA_BIT  = 21;
   localparam int CMD_MULTI_BIT = 5;
   localparam int CMD_DIR_BIT   = 4;
   localparam int CMD_CNTEN_BIT = 1;
   localparam int SETUP_CNT_LSB = 16;
endpackage

// File: rtl/sdx_blk_cfg.sv
module sdx_blk_cfg #(
   parameter int LEN_W  = 12,
   parameter int CNT_W  = 16,
   parameter int BPW    = 4,
   parameter int WORD_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              blk_wr,
   input  logic [31:0]       blk_wdata,
   output logic [WORD_W-1:0] wpb,
   output logic [CNT_W-1:0]  cnt
);
   localparam int SH = $clog2(BPW);

   logic [LEN_W-1:0] len_q;
   logic [LEN_W:0]   words;
   logic             unused_setup;

   assign unused_setup = ^blk_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_q <= '0;
         cnt   <= '0;
      end else if (blk_wr) begin
         len_q <= blk_wdata[LEN_W-1:0];
         cnt   <= blk_wdata[sdx_pkg::SETUP_CNT_LSB +: CNT_W];
      end
   end

   generate
      if (SH == 0) begin : g_byte_port
         assign words = {1'b0, len_q};
      end else begin : g_wide_port
         logic [LEN_W:0] rounded;
         assign rounded = {1'b0, len_q} + (LEN_W+1)'(BPW - 1);
         assign words   = rounded >> SH;
      end
   endgenerate

   assign wpb = (words[WORD_W-1:0] == '0) ? WORD_W'(1) : words[WORD_W-1:0];
endmodule

// File: rtl/sdx_word_ctr.sv
module sdx_word_ctr #(
   parameter int WORD_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] load_val,
   input  logic              dec,
   output logic [WORD_W-1:0] cnt,
   output logic              last
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt <= '0;
      else if (load)     cnt <= load_val;
      else if (dec)      cnt <= cnt - WORD_W'(1);
   end

   assign last = (cnt == WORD_W'(1));
endmodule

// File: rtl/sdx_seq_fsm.sv
module sdx_seq_fsm
   import sdx_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter int WORD_W   = 11,
   parameter int FILL_LAT = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_wr,
   input  logic [31:0]       cmd_wdata,
   input  logic [CNT_W-1:0]  cfg_cnt,
   input  logic [WORD_W-1:0] cfg_wpb,
   input  logic              dport_rd,
   input  logic              dport_wr,
   input  logic              word_last,
   output sdx_state_e        state,
   output logic              dir_rd,
   output logic              brr_evt,
   output logic              bwr_evt,
   output logic              tc_evt,
   output logic [CNT_W-1:0]  blocks_left,
   output logic              word_load,
   output logic [WORD_W-1:0] word_load_val,
   output logic              word_dec
);
   localparam int FC_W = (FILL_LAT > 1) ? $clog2(FILL_LAT) : 1;

   logic [FC_W-1:0]  fcnt;
   logic [WORD_W-1:0] wpb_run;
   logic             start, counted, acc, unused_cmd;
   logic [CNT_W-1:0] nblk;

   assign unused_cmd = ^cmd_wdata;
   assign start      = cmd_wr && (state == SQ_IDLE) && cmd_wdata[CMD_DATA_BIT];
   assign counted    = cmd_wdata[CMD_MULTI_BIT] && cmd_wdata[CMD_CNTEN_BIT];
   assign nblk       = counted ? cfg_cnt : CNT_W'(1);
   assign acc        = (state == SQ_OPEN) && (dir_rd ? dport_rd : dport_wr);

   assign word_dec      = acc;
   assign word_load     = (state == SQ_FILL) && (fcnt == '0);
   assign word_load_val = wpb_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= SQ_IDLE;
         dir_rd      <= 1'b0;
         fcnt        <= '0;
         wpb_run     <= '0;
         blocks_left <= '0;
         brr_evt     <= 1'b0;
         bwr_evt     <= 1'b0;
         tc_evt      <= 1'b0;
      end else begin
         brr_evt <= 1'b0;
         bwr_evt <= 1'b0;
         tc_evt  <= 1'b0;
         unique case (state)
            SQ_IDLE: begin
               if (start) begin
                  dir_rd      <= cmd_wdata[CMD_DIR_BIT];
                  wpb_run     <= cfg_wpb;
                  blocks_left <= nblk;
                  if (nblk == '0) begin
                     tc_evt <= 1'b1;
                  end else begin
                     state <= SQ_FILL;
                     fcnt  <= FC_W'(FILL_LAT - 1);
                  end
               end
            end
            SQ_FILL: begin
               if (fcnt == '0) begin
                  state   <= SQ_OPEN;
                  brr_evt <= dir_rd;
                  bwr_evt <= !dir_rd;
               end else begin
                  fcnt <= fcnt - FC_W'(1);
               end
            end
            SQ_OPEN: begin
               if (acc && word_last) begin
                  blocks_left <= blocks_left - CNT_W'(1);
                  if (blocks_left == CNT_W'(1)) begin
                     state  <= SQ_IDLE;
                     tc_evt <= 1'b1;
                  end else begin
                     state <= SQ_FILL;
                     fcnt  <= FC_W'(FILL_LAT - 1);
                  end
               end
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sd_xfer_seq.sv
module sd_xfer_seq #(
   parameter int LEN_W    = 12,
   parameter int CNT_W    = 16,
   parameter int DATA_W   = 32,
   parameter int FILL_LAT = 2,
   localparam int BPW     = DATA_W / 8,
   localparam int WORD_W  = LEN_W + 1 - $clog2(BPW)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              blk_wr,
   input  logic [31:0]       blk_wdata,
   input  logic              cmd_wr,
   input  logic [31:0]       cmd_wdata,
   input  logic              dport_rd,
   input  logic              dport_wr,
   output logic              busy,
   output logic              rd_open,
   output logic              wr_open,
   output logic              brr_evt,
   output logic              bwr_evt,
   output logic              tc_evt,
   output logic [CNT_W-1:0]  blocks_left,
   output logic [WORD_W-1:0] words_left
);
   import sdx_pkg::*;

   generate
      if (LEN_W < 1 || LEN_W > 16) begin : g_bad_len
         $error("LEN_W must fit below the count field");
      end
      if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
         $error("CNT_W must fit in the upper half of the setup word");
      end
      if (DATA_W < 8 || (DATA_W % 8) != 0 || (1 << $clog2(BPW)) != BPW) begin : g_bad_data
         $error("DATA_W must be a power-of-two number of bytes");
      end
      if (FILL_LAT < 1) begin : g_bad_fill
         $error("FILL_LAT must be at least one cycle");
      end
   endgenerate

   logic [WORD_W-1:0] cfg_wpb, load_val;
   logic [CNT_W-1:0]  cfg_cnt;
   logic              word_last, word_load, word_dec, dir_rd;
   sdx_state_e        state;

   sdx_blk_cfg #(
      .LEN_W(LEN_W), .CNT_W(CNT_W), .BPW(BPW), .WORD_W(WORD_W)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .blk_wr(blk_wr), .blk_wdata(blk_wdata),
      .wpb(cfg_wpb), .cnt(cfg_cnt)
   );

   sdx_seq_fsm #(
      .CNT_W(CNT_W), .WORD_W(WORD_W), .FILL_LAT(FILL_LAT)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
      .cfg_cnt(cfg_cnt), .cfg_wpb(cfg_wpb), .dport_rd(dport_rd),
      .dport_wr(dport_wr), .word_last(word_last), .state(state),
      .dir_rd(dir_rd), .brr_evt(brr_evt), .bwr_evt(bwr_evt), .tc_evt(tc_evt),
      .blocks_left(blocks_left), .word_load(word_load),
      .word_load_val(load_val), .word_dec(word_dec)
   );

   sdx_word_ctr #(
      .WORD_W(WORD_W)
   ) u_words (
      .clk(clk), .rst_n(rst_n), .load(word_load), .load_val(load_val),
      .dec(word_dec), .cnt(words_left), .last(word_last)
   );

   assign busy    = (state != SQ_IDLE);
   assign rd_open = (state == SQ_OPEN) && dir_rd;
   assign wr_open = (state == SQ_OPEN) && !dir_rd;
endmodule

// File: rtl/sd_xfer_seq_chk.sv
module sd_xfer_seq_chk #(
   parameter int CNT_W  = 16,
   parameter int WORD_W = 11
) (
   input logic              clk,
   input logic              rst_n,
   input logic              dport_rd,
   input logic              dport_wr,
   input logic              busy,
   input logic              rd_open,
   input logic              wr_open,
   input logic              brr_evt,
   input logic              bwr_evt,
   input logic              tc_evt,
   input logic [CNT_W-1:0]  blocks_left,
   input logic [WORD_W-1:0] words_left
);
   logic good_acc;
   assign good_acc = (rd_open && dport_rd) || (wr_open && dport_wr);

   p_open_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rd_open, wr_open}));

   p_brr_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
      brr_evt |-> rd_open);

   p_bwr_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
      bwr_evt |-> wr_open);

   p_evt_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (brr_evt || bwr_evt) |=> !(brr_evt || bwr_evt));

   p_evt_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({brr_evt, bwr_evt, tc_evt}));

   p_tc_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tc_evt |-> !busy);

   p_words_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !good_acc |=> ($stable(words_left) || brr_evt || bwr_evt));

   p_blocks_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !good_acc) |=> $stable(blocks_left));
endmodule

bind sd_xfer_seq sd_xfer_seq_chk #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .dport_rd(dport_rd), .dport_wr(dport_wr),
   .busy(busy), .rd_open(rd_open), .wr_open(wr_open), .brr_evt(brr_evt),
   .bwr_evt(bwr_evt), .tc_evt(tc_evt), .blocks_left(blocks_left),
   .words_left(words_left)
);

// File: tb/tb_sd_xfer_seq.sv
`timescale 1ns/1ps
module tb_sd_xfer_seq;
   localparam int FILL_LAT = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        blk_wr = 1'b0, cmd_wr = 1'b0, dport_rd = 1'b0, dport_wr = 1'b0;
   logic [31:0] blk_wdata = '0, cmd_wdata = '0;
   logic        busy, rd_open, wr_open, brr_evt, bwr_evt, tc_evt;
   logic [15:0] blocks_left;
   logic [10:0] words_left;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   sd_xfer_seq #(.FILL_LAT(FILL_LAT)) dut (
      .clk(clk), .rst_n(rst_n), .blk_wr(blk_wr), .blk_wdata(blk_wdata),
      .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .dport_rd(dport_rd),
      .dport_wr(dport_wr), .busy(busy), .rd_open(rd_open), .wr_open(wr_open),
      .brr_evt(brr_evt), .bwr_evt(bwr_evt), .tc_evt(tc_evt),
      .blocks_left(blocks_left), .words_left(words_left)
   );

   task automatic check(string req, string what, longint act, longint exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int exp_wpb(int len);
      return (len == 0) ? 1 : (len + 3) / 4;
   endfunction

   function automatic int exp_nblk(bit multi, bit cnten, int cnt);
      return (multi && cnten) ? cnt : 1;
   endfunction

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic write_setup(int len, int cnt, bit [3:0] junk);
      blk_wr    = 1'b1;
      blk_wdata = {cnt[15:0], junk, len[11:0]};
      step();
      blk_wr = 1'b0;
   endtask

   task automatic word_access(bit rd);
      dport_rd = rd;
      dport_wr = !rd;
      step();
      dport_rd = 1'b0;
      dport_wr = 1'b0;
   endtask

   task automatic run_xfer(int len, int cnt, bit rd, bit multi, bit cnten,
                           bit noise, bit mid_cmd);
      int nb = exp_nblk(multi, cnten, cnt);
      int wp = exp_wpb(len);
      write_setup(len, cnt, 4'($urandom));
      cmd_wdata = (32'd1 << 21) | (32'(rd) << 4) | (32'(multi) << 5) |
                  (32'(cnten) << 1) | (32'($urandom % 64) << 24);
      cmd_wr = 1'b1;
      step();
      cmd_wr = 1'b0;
      if (nb == 0) begin
         check("R9", "tc_evt zero count", tc_evt, 1);
         check("R9", "busy zero count", busy, 0);
         check("R9", "no ready event", brr_evt | bwr_evt, 0);
         step();
         check("R9", "tc_evt single cycle", tc_evt, 0);
         return;
      end
      check("R2", "busy after data command", busy, 1);
      for (int b = 0; b < nb; b++) begin
         int wait_cyc = FILL_LAT;
         if (noise && b > 0) begin
            word_access(rd);
            check("R7", "access during refill ignored", words_left, 0);
            wait_cyc--;
         end
         for (int i = 0; i < wait_cyc; i++) step();
         check("R5", "ready event", rd ? brr_evt : bwr_evt, 1);
         check("R5", "other event quiet", rd ? bwr_evt : brr_evt, 0);
         check("R5", "window open level", rd ? rd_open : wr_open, 1);
         check("R1", "words per block", words_left, wp);
         check((multi && cnten) ? "R4" : "R3", "blocks left", blocks_left, nb - b);
         if (b == 0 && mid_cmd) begin
            write_setup(len + 40, cnt + 3, 4'h0);
            cmd_wdata = (32'd1 << 21) | (32'(!rd) << 4) | 32'h22;
            cmd_wr = 1'b1;
            step();
            cmd_wr = 1'b0;
            check("R10", "words kept under busy command", words_left, wp);
            check("R10", "blocks kept under busy command", blocks_left, nb);
            check("R10", "direction kept", rd ? rd_open : wr_open, 1);
         end
         for (int w = 0; w < wp; w++) begin
            if (noise && ($urandom % 2 == 1)) begin
               word_access(!rd);
               check("R7", "wrong direction words", words_left, wp - w);
               check("R7", "wrong direction blocks", blocks_left, nb - b);
            end
            word_access(rd);
            check("R6", "word decrement", words_left, wp - w - 1);
            check("R5", "event is one cycle", brr_evt | bwr_evt, 0);
         end
         if (b == nb - 1) begin
            check("R8", "tc_evt after last word", tc_evt, 1);
            check("R8", "busy drops", busy, 0);
            check("R8", "blocks left zero", blocks_left, 0);
         end else begin
            check("R6", "window closed", rd_open | wr_open, 0);
            check("R6", "still busy", busy, 1);
            check("R8", "no early tc", tc_evt, 0);
         end
      end
      step();
      check("R8", "tc_evt single cycle", tc_evt, 0);
      check("R8", "idle after transfer", busy, 0);
   endtask

   initial begin
      #900000;
      if (!finished) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5D1C0DE));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R11", "reset busy", busy, 0);
      check("R11", "reset open", rd_open | wr_open, 0);
      check("R11", "reset events", {brr_evt, bwr_evt, tc_evt}, 0);
      check("R11", "reset blocks", blocks_left, 0);
      check("R11", "reset words", words_left, 0);

      // R2: command without data-present does nothing
      write_setup(16, 2, 4'h0);
      cmd_wdata = 32'h0000_0032;
      cmd_wr = 1'b1;
      step();
      cmd_wr = 1'b0;
      check("R2", "no data command stays idle", busy, 0);
      step();
      check("R2", "no event without data", {brr_evt, bwr_evt, tc_evt}, 0);

      // R7: accesses while idle
      word_access(1'b1);
      word_access(1'b0);
      check("R7", "idle access words", words_left, 0);
      check("R7", "idle access blocks", blocks_left, 0);

      run_xfer(16, 7, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);  // R3 multi without count enable
      run_xfer(16, 7, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);  // R3 count enable alone
      run_xfer(20, 3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);  // R4 counted read
      run_xfer(8, 4, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);   // R4 counted write
      run_xfer(0, 2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);   // R1 zero length
      run_xfer(5, 1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);   // R1 rounding up
      run_xfer(512, 1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0); // R1 full sector
      run_xfer(12, 0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);  // R9 zero count
      run_xfer(12, 3, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);  // R10 busy command

      for (int t = 0; t < 25; t++) begin
         run_xfer(int'($urandom % 64), int'($urandom % 5), 1'($urandom),
                  1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom % 4 == 0));
      end

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule